// File: doc/BRIEF.md
# Two-Wire Debug Link Host Transaction Engine

This block is the host end of a two-wire serial debug link. A single command runs one complete transaction with either the debug port or an access port of a target. The engine makes the link clock from the system clock through a programmable divider. It drives the shared data line while the host owns it and releases it for the target's bits. Each transaction sends an 8-bit request, reads a 3-bit acknowledge from the target, and then moves a 32-bit word plus a parity bit. Reads flow from the target and writes flow from the host.

When the target answers WAIT, the engine sends the identical request again. The number of reissues is capped by a programmable limit. When that limit is used up, the engine reports a timeout. A FAULT answer or a reserved acknowledge ends the transaction without a data phase. On completion, a one-cycle done pulse carries a result code, the raw acknowledge, the read word and a read parity-error flag. The register address is the two-bit field A[3:2]. For example, 0x0, 0x8 and 0xC on the debug port give address codes 0, 2 and 3.

Top module: `dbg2w_host`

## Requirements
- R1: A command is taken on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low from the next cycle until the cycle in which `done` pulses. `done` is high for exactly one cycle, and `result`, `ack`, `rdata` and `parity_err` are valid in that cycle.
- R2: Every link bit lasts 2*(`clk_div`+1) system cycles: a low half of `dclk` followed by a high half. `dclk` and `dio_oe` are low while the engine is idle. The host changes `dio_out` and `dio_oe` only at the start of a low half.
- R3: The request is sent in this order, with the host driving: 1, write flag, port flag (0 debug port, 1 access port), `cmd_addr[0]`, `cmd_addr[1]`, parity, 0, 1. With the default `ODD_PARITY`=1, the parity bit makes the count of ones over write, port, both address bits and parity odd. With `ODD_PARITY`=0, that count is even.
- R4: The request is followed by one turnaround bit and then three acknowledge bits. `dio_oe` is low in all four. The first acknowledge bit received becomes `ack[0]`.
- R5: The acknowledge codes are 3'b001 OK, 3'b010 WAIT and 3'b100 FAULT; every other code is a protocol error. The `result` codes are 0 OK, 1 WAIT timeout, 2 FAULT and 3 protocol error. `ack` returns the last acknowledge received.
- R6: On a read with an OK acknowledge, the host keeps the line released and samples 32 data bits, least significant bit first, then a parity bit. One turnaround bit follows, then one idle bit that the host drives low. `parity_err` is set when the parity bit disagrees with the data under the same parity rule as R3.
- R7: On a write with an OK acknowledge, one turnaround bit with `dio_oe` low follows. The host then drives 32 data bits, least significant bit first, and the parity bit of R3's rule, then one idle bit driven low.
- R8: On WAIT, one turnaround bit follows and then the identical request is sent again. At most `retry_limit` reissues are made. A WAIT on the final permitted attempt ends the transaction with `result` 1.
- R9: On FAULT or a protocol-error acknowledge, one turnaround bit follows and the transaction ends. There is no data phase and the host does not drive the line.
- R10: `done` rises N*2*(`clk_div`+1) cycles after the accepting edge. N is 47 for a transaction with a data phase, plus 13 for each attempt that ended in WAIT. N is 13 for a single attempt that ends without data.
- R11: `clk_div` and `retry_limit` are captured when the command is taken. Changing them during a transaction has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_write | input | 1 | 1 write, 0 read |
| cmd_ap | input | 1 | 1 access port, 0 debug port |
| cmd_addr | input | 2 | Register address bits A[3:2] |
| cmd_wdata | input | 32 | Write data |
| clk_div | input | DIV_W | Half-bit length minus one, in system cycles |
| retry_limit | input | RETRY_W | Maximum reissues after WAIT |
| dclk | output | 1 | Link clock |
| dio_out | output | 1 | Data line value driven by the host |
| dio_oe | output | 1 | Host drives the data line when high |
| dio_in | input | 1 | Data line value seen by the host |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | Completion code |
| ack | output | 3 | Last acknowledge received |
| rdata | output | 32 | Last read word |
| parity_err | output | 1 | Read parity mismatch |

## Verification
Every result of this block is due at a fixed number of system cycles after the accepting edge. That number is the bit count of the transaction times 2*(`clk_div`+1). The bench counts falling system-clock edges from the accept until `done` is seen and compares that count with the value from R10 for each scenario. The result fields are checked in that same cycle, and `done` is checked to be low one cycle later. The bench's target model reacts to link clock edges, never to system-clock timing. It records the host's line state at each rising `dclk`, so the request, turnaround and data bits are checked by bit position within the transaction.

// File: rtl/dbg2w_pkg.sv
package dbg2w_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REQ,
        ST_TA_REQ,
        ST_ACK,
        ST_TA_ACK,
        ST_WR,
        ST_RD,
        ST_TA_RD,
        ST_TAIL
    } st_e;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_TIMEOUT = 2'd1,
        RES_FAULT   = 2'd2,
        RES_PROTO   = 2'd3
    } res_e;

    localparam logic [2:0] ACK_OK    = 3'b001;
    localparam logic [2:0] ACK_WAIT  = 3'b010;
    localparam logic [2:0] ACK_FAULT = 3'b100;

    typedef struct packed {
        logic              write;
        logic              ap;
        logic [1:0]        addr;
        logic [DATA_W-1:0] wdata;
    } cmd_t;

    // parity bit that makes the total count of ones odd (odd=1) or even (odd=0)
    function automatic logic data_par(input logic [DATA_W-1:0] v, input logic odd);
        return (^v) ^ odd;
    endfunction

    // request bits, bit 0 leaves the host first
    function automatic logic [7:0] build_req(input logic wr, input logic ap,
                                             input logic [1:0] addr, input logic odd);
        logic p;
        p = (wr ^ ap ^ addr[0] ^ addr[1]) ^ odd;
        return {1'b1, 1'b0, p, addr[1], addr[0], ap, wr, 1'b1};
    endfunction

    function automatic res_e classify(input logic [2:0] a);
        if (a == ACK_WAIT)  return RES_TIMEOUT;
        if (a == ACK_FAULT) return RES_FAULT;
        return RES_PROTO;
    endfunction

endpackage

// File: rtl/dbg2w_clkgen.sv
module dbg2w_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             dclk,
    output logic             rise,
    output logic             bend
);
    logic [DIV_W-1:0] cnt;
    logic             ph;
    logic             wrap;

    assign wrap = (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            ph  <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            ph  <= ~ph;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign dclk = ph;
    assign rise = run && !ph && wrap;   // last cycle of low half: sample here
    assign bend = run &&  ph && wrap;   // last cycle of high half: next bit starts
endmodule

// File: rtl/dbg2w_seq.sv
module dbg2w_seq
    import dbg2w_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int RETRY_W    = 4,
    parameter bit ODD_PARITY = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  cmd_t               cmd,
    input  logic [DIV_W-1:0]   clk_div,
    input  logic [RETRY_W-1:0] retry_limit,
    input  logic               rise,
    input  logic               bend,
    input  logic               dio_in,
    output logic               cmd_ready,
    output logic               busy,
    output logic [DIV_W-1:0]   div_q,
    output logic               dio_out,
    output logic               dio_oe,
    output logic               done,
    output logic [1:0]         result,
    output logic [2:0]         ack,
    output logic [DATA_W-1:0]  rdata,
    output logic               parity_err,
    output st_e                state_o,
    output logic [RETRY_W-1:0] retries_o,
    output logic [RETRY_W-1:0] lim_o
);
    localparam logic [5:0] REQ_LAST  = 6'd7;
    localparam logic [5:0] ACK_LAST  = 6'd2;
    localparam logic [5:0] DATA_LAST = 6'(DATA_W);

    st_e                st;
    logic [5:0]         bitcnt;
    logic [7:0]         req_q;
    logic [DATA_W:0]    wr_sh;
    logic [DATA_W:0]    rd_sh;
    logic [2:0]         ack_sh;
    logic               wr_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [RETRY_W-1:0] retries;
    logic [RETRY_W-1:0] lim_q;

    assign cmd_ready = (st == ST_IDLE);
    assign busy      = (st != ST_IDLE);
    assign state_o   = st;
    assign retries_o = retries;
    assign lim_o     = lim_q;

    always_comb begin
        dio_oe  = (st == ST_REQ) || (st == ST_WR) || (st == ST_TAIL);
        case (st)
            ST_REQ:  dio_out = req_q[bitcnt[2:0]];
            ST_WR:   dio_out = wr_sh[0];
            default: dio_out = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            bitcnt     <= '0;
            req_q      <= '0;
            wr_sh      <= '0;
            rd_sh      <= '0;
            ack_sh     <= '0;
            wr_q       <= 1'b0;
            wdata_q    <= '0;
            retries    <= '0;
            lim_q      <= '0;
            div_q      <= '0;
            done       <= 1'b0;
            result     <= RES_OK;
            ack        <= '0;
            rdata      <= '0;
            parity_err <= 1'b0;
        end else begin
            done <= 1'b0;
            if (st == ST_IDLE) begin
                if (cmd_valid) begin
                    req_q   <= build_req(cmd.write, cmd.ap, cmd.addr, ODD_PARITY);
                    wr_q    <= cmd.write;
                    wdata_q <= cmd.wdata;
                    div_q   <= clk_div;
                    lim_q   <= retry_limit;
                    retries <= '0;
                    bitcnt  <= '0;
                    st      <= ST_REQ;
                end
            end else begin
                if (rise) begin
                    if (st == ST_ACK) ack_sh <= {dio_in, ack_sh[2:1]};
                    if (st == ST_RD)  rd_sh  <= {dio_in, rd_sh[DATA_W:1]};
                end
                if (bend) begin
                    bitcnt <= bitcnt + 6'd1;
                    case (st)
                        ST_REQ: if (bitcnt == REQ_LAST) begin
                            st     <= ST_TA_REQ;
                            bitcnt <= '0;
                        end
                        ST_TA_REQ: begin
                            st     <= ST_ACK;
                            bitcnt <= '0;
                        end
                        ST_ACK: if (bitcnt == ACK_LAST) begin
                            bitcnt <= '0;
                            st     <= (ack_sh == ACK_OK && !wr_q) ? ST_RD : ST_TA_ACK;
                        end
                        ST_TA_ACK: begin
                            bitcnt <= '0;
                            if (ack_sh == ACK_OK) begin
                                st    <= ST_WR;
                                wr_sh <= {data_par(wdata_q, ODD_PARITY), wdata_q};
                            end else if (ack_sh == ACK_WAIT && retries != lim_q) begin
                                st      <= ST_REQ;
                                retries <= retries + 1'b1;
                            end else begin
                                st         <= ST_IDLE;
                                done       <= 1'b1;
                                ack        <= ack_sh;
                                result     <= classify(ack_sh);
                                parity_err <= 1'b0;
                            end
                        end
                        ST_WR: begin
                            wr_sh <= {1'b0, wr_sh[DATA_W:1]};
                            if (bitcnt == DATA_LAST) begin
                                st     <= ST_TAIL;
                                bitcnt <= '0;
                            end
                        end
                        ST_RD: if (bitcnt == DATA_LAST) begin
                            st     <= ST_TA_RD;
                            bitcnt <= '0;
                        end
                        ST_TA_RD: begin
                            st     <= ST_TAIL;
                            bitcnt <= '0;
                        end
                        ST_TAIL: begin
                            st     <= ST_IDLE;
                            done   <= 1'b1;
                            ack    <= ack_sh;
                            result <= RES_OK;
                            if (!wr_q) begin
                                rdata      <= rd_sh[DATA_W-1:0];
                                parity_err <= rd_sh[DATA_W] !=
                                              data_par(rd_sh[DATA_W-1:0], ODD_PARITY);
                            end else begin
                                parity_err <= 1'b0;
                            end
                        end
                        default: st <= ST_IDLE;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/dbg2w_host.sv
module dbg2w_host
    import dbg2w_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int RETRY_W    = 4,
    parameter bit ODD_PARITY = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic               cmd_write,
    input  logic               cmd_ap,
    input  logic [1:0]         cmd_addr,
    input  logic [31:0]        cmd_wdata,
    input  logic [DIV_W-1:0]   clk_div,
    input  logic [RETRY_W-1:0] retry_limit,
    output logic               dclk,
    output logic               dio_out,
    output logic               dio_oe,
    input  logic               dio_in,
    output logic               done,
    output logic [1:0]         result,
    output logic [2:0]         ack,
    output logic [31:0]        rdata,
    output logic               parity_err
);
    cmd_t               cmd;
    logic               busy;
    logic               rise;
    logic               bend;
    logic [DIV_W-1:0]   div_q;
    st_e                seq_state;
    logic [RETRY_W-1:0] seq_retries;
    logic [RETRY_W-1:0] seq_lim;

    assign cmd = '{write: cmd_write, ap: cmd_ap, addr: cmd_addr, wdata: cmd_wdata};

    dbg2w_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .div  (div_q),
        .dclk (dclk),
        .rise (rise),
        .bend (bend)
    );

    dbg2w_seq #(
        .DIV_W      (DIV_W),
        .RETRY_W    (RETRY_W),
        .ODD_PARITY (ODD_PARITY)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd         (cmd),
        .clk_div     (clk_div),
        .retry_limit (retry_limit),
        .rise        (rise),
        .bend        (bend),
        .dio_in      (dio_in),
        .cmd_ready   (cmd_ready),
        .busy        (busy),
        .div_q       (div_q),
        .dio_out     (dio_out),
        .dio_oe      (dio_oe),
        .done        (done),
        .result      (result),
        .ack         (ack),
        .rdata       (rdata),
        .parity_err  (parity_err),
        .state_o     (seq_state),
        .retries_o   (seq_retries),
        .lim_o       (seq_lim)
    );
endmodule

// File: rtl/dbg2w_host_chk.sv
module dbg2w_host_chk
    import dbg2w_pkg::*;
#(
    parameter int RETRY_W = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               cmd_ready,
    input logic               dclk,
    input logic               dio_out,
    input logic               dio_oe,
    input logic               done,
    input logic [1:0]         result,
    input logic [2:0]         ack,
    input st_e                state,
    input logic [RETRY_W-1:0] retries,
    input logic [RETRY_W-1:0] lim
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                   // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> (!dclk && !dio_oe));                                 // R2

    AST_HOLD_IN_HIGH: assert property (@(posedge clk) disable iff (rst)
        (dclk && $past(dclk)) |-> ($stable(dio_out) && $stable(dio_oe)));  // R2

    AST_START_BIT: assert property (@(posedge clk) disable iff (rst)
        ($past(cmd_ready) && !cmd_ready) |-> (dio_oe && dio_out));         // R3

    AST_ACK_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (dclk && (state == ST_TA_REQ || state == ST_ACK)) |-> !dio_oe);    // R4

    AST_OK_CODE: assert property (@(posedge clk) disable iff (rst)
        (done && result == 2'd0) |-> (ack == ACK_OK));                     // R5

    AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (rst)
        retries <= lim);                                                   // R8

    AST_TIMEOUT_CODE: assert property (@(posedge clk) disable iff (rst)
        (done && result == 2'd1) |-> (ack == ACK_WAIT));                   // R8
endmodule

bind dbg2w_host dbg2w_host_chk #(.RETRY_W(RETRY_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_ready (cmd_ready),
    .dclk      (dclk),
    .dio_out   (dio_out),
    .dio_oe    (dio_oe),
    .done      (done),
    .result    (result),
    .ack       (ack),
    .state     (seq_state),
    .retries   (seq_retries),
    .lim       (seq_lim)
);

// File: tb/dbg2w_host_tb.sv
module dbg2w_host_tb;
    localparam logic [2:0] K_OK    = 3'b001;
    localparam logic [2:0] K_WAIT  = 3'b010;
    localparam logic [2:0] K_FAULT = 3'b100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_write = 1'b0;
    logic        cmd_ap = 1'b0;
    logic [1:0]  cmd_addr = 2'd0;
    logic [31:0] cmd_wdata = '0;
    logic [7:0]  clk_div = 8'd0;
    logic [3:0]  retry_limit = 4'd0;
    logic        dclk;
    logic        dio_out;
    logic        dio_oe;
    logic        dio_in = 1'b1;
    logic        done;
    logic [1:0]  result;
    logic [2:0]  ack;
    logic [31:0] rdata;
    logic        parity_err;

    always #10 clk = ~clk;

    dbg2w_host u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_write(cmd_write), .cmd_ap(cmd_ap), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .clk_div(clk_div), .retry_limit(retry_limit),
        .dclk(dclk), .dio_out(dio_out), .dio_oe(dio_oe), .dio_in(dio_in),
        .done(done), .result(result), .ack(ack), .rdata(rdata),
        .parity_err(parity_err)
    );

    int n_chk = 0;
    int n_fail = 0;

    // target model state
    logic        t_write = 1'b0;
    int          t_nwait = 0;
    logic [2:0]  t_final = K_OK;
    logic [31:0] t_rdata = '0;
    logic        t_corrupt = 1'b0;
    int          t_pos = 0;
    int          t_gpos = 0;
    int          t_attempt = 0;
    logic        rec_out [0:255];
    logic        rec_oe  [0:255];
    logic        prev_dclk = 1'b0;

    // results of the last run
    int   g_cyc;
    logic g_done_next;
    logic g_ready_mid;

    function automatic logic [2:0] cur_ack();
        return (t_attempt < t_nwait) ? K_WAIT : t_final;
    endfunction

    function automatic logic odd_par(input logic [31:0] v);
        return ~(^v);
    endfunction

    function automatic logic [7:0] exp_req(input logic w, input logic ap, input logic [1:0] a);
        logic p;
        p = ~(w ^ ap ^ a[0] ^ a[1]);
        return {1'b1, 1'b0, p, a[1], a[0], ap, w, 1'b1};
    endfunction

    function automatic logic tgt_bit(input int pos);
        logic [2:0] k;
        k = cur_ack();
        if (pos >= 9 && pos <= 11) return k[pos-9];
        if (k == K_OK && !t_write && pos >= 12 && pos <= 43) return t_rdata[pos-12];
        if (k == K_OK && !t_write && pos == 44) return odd_par(t_rdata) ^ t_corrupt;
        return 1'b1;
    endfunction

    function automatic logic [7:0] rec_byte(input int base);
        logic [7:0] v;
        for (int i = 0; i < 8; i++) v[i] = rec_out[base+i];
        return v;
    endfunction

    function automatic int oe_count(input int lo, input int hi);
        int c;
        c = 0;
        for (int i = lo; i <= hi; i++) if (rec_oe[i] === 1'b1) c++;
        return c;
    endfunction

    // target: present its bit after dclk falls, record the host at each dclk rise
    initial begin
        forever begin
            @(negedge clk);
            if (dclk && !prev_dclk) begin
                if (t_gpos < 256) begin
                    rec_out[t_gpos] = dio_out;
                    rec_oe[t_gpos]  = dio_oe;
                end
                t_gpos++;
                t_pos++;
                if (cur_ack() != K_OK && t_pos == 13) begin
                    t_pos = 0;
                    t_attempt++;
                end
            end else if (!dclk && prev_dclk) begin
                dio_in = tgt_bit(t_pos);
            end
            prev_dclk = dclk;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_txn(input logic w, input logic ap, input logic [1:0] a,
                           input logic [31:0] wd, input logic [7:0] div,
                           input logic [3:0] lim, input int nwait,
                           input logic [2:0] fin, input logic [31:0] rv,
                           input logic corrupt, input int newdiv);
        t_write = w; t_nwait = nwait; t_final = fin; t_rdata = rv;
        t_corrupt = corrupt; t_pos = 0; t_gpos = 0; t_attempt = 0;
        for (int i = 0; i < 256; i++) begin rec_out[i] = 1'bx; rec_oe[i] = 1'bx; end
        @(negedge clk);
        cmd_write = w; cmd_ap = ap; cmd_addr = a; cmd_wdata = wd;
        clk_div = div; retry_limit = lim; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (newdiv >= 0) begin
            clk_div = 8'(newdiv);
            retry_limit = 4'd0;
        end
        g_ready_mid = cmd_ready;
        g_cyc = 0;
        while (!done && g_cyc < 5000) begin
            @(negedge clk);
            g_cyc++;
        end
        @(negedge clk);
        g_done_next = done;
    endtask

    task automatic t_reset;
        chk("R1 ready after reset", 64'(cmd_ready), 64'd1);
        chk("R1 done low after reset", 64'(done), 64'd0);
        chk("R2 dclk low idle", 64'(dclk), 64'd0);
        chk("R2 oe low idle", 64'(dio_oe), 64'd0);
    endtask

    task automatic t_read_ok;
        run_txn(1'b0, 1'b0, 2'b11, 32'h0, 8'd0, 4'd2, 0, K_OK, 32'hA5C3_0F96, 1'b0, -1);
        chk("R1 ready low while busy", 64'(g_ready_mid), 64'd0);
        chk("R1 done one cycle", 64'(g_done_next), 64'd0);
        chk("R10 read cycles div0", 64'(g_cyc), 64'd94);
        chk("R3 request bits", 64'(rec_byte(0)), 64'(exp_req(1'b0, 1'b0, 2'b11)));
        chk("R3 request driven", 64'(oe_count(0, 7)), 64'd8);
        chk("R4 released turn+ack", 64'(oe_count(8, 11)), 64'd0);
        chk("R6 released data+turn", 64'(oe_count(12, 45)), 64'd0);
        chk("R6 idle bit driven low", 64'({rec_oe[46], rec_out[46]}), 64'b10);
        chk("R6 bit count", 64'(t_gpos), 64'd47);
        chk("R6 read data", 64'(rdata), 64'hA5C3_0F96);
        chk("R6 no parity error", 64'(parity_err), 64'd0);
        chk("R5 ok result", 64'(result), 64'd0);
        chk("R5 ok ack", 64'(ack), 64'(K_OK));
    endtask

    task automatic t_read_slow;
        run_txn(1'b0, 1'b1, 2'b01, 32'h0, 8'd2, 4'd1, 0, K_OK, 32'h0000_8001, 1'b0, 7);
        chk("R11 divider captured at accept", 64'(g_cyc), 64'd282);
        chk("R2 bit length div2", 64'(g_cyc), 64'(47 * 2 * 3));
        chk("R3 request ap addr1", 64'(rec_byte(0)), 64'(exp_req(1'b0, 1'b1, 2'b01)));
        chk("R6 read data slow", 64'(rdata), 64'h0000_8001);
    endtask

    task automatic t_write_ok;
        logic [31:0] wd;
        run_txn(1'b1, 1'b0, 2'b10, 32'h1234_5678, 8'd1, 4'd0, 0, K_OK, 32'h0, 1'b0, -1);
        for (int i = 0; i < 32; i++) wd[i] = rec_out[13+i];
        chk("R10 write cycles div1", 64'(g_cyc), 64'd188);
        chk("R3 request write", 64'(rec_byte(0)), 64'(exp_req(1'b1, 1'b0, 2'b10)));
        chk("R7 turnaround released", 64'(rec_oe[12]), 64'd0);
        chk("R7 data driven", 64'(oe_count(13, 46)), 64'd34);
        chk("R7 write data", 64'(wd), 64'h1234_5678);
        chk("R7 write parity", 64'(rec_out[45]), 64'(odd_par(32'h1234_5678)));
        chk("R7 idle bit low", 64'(rec_out[46]), 64'd0);
        chk("R7 ok result", 64'(result), 64'd0);
    endtask

    task automatic t_parity_bad;
        run_txn(1'b0, 1'b1, 2'b00, 32'h0, 8'd0, 4'd0, 0, K_OK, 32'hFFFF_0000, 1'b1, -1);
        chk("R6 parity error flagged", 64'(parity_err), 64'd1);
        chk("R6 data kept on parity error", 64'(rdata), 64'hFFFF_0000);
    endtask

    task automatic t_wait_retry;
        run_txn(1'b0, 1'b0, 2'b00, 32'h0, 8'd0, 4'd3, 2, K_OK, 32'h0BAD_F00D, 1'b0, -1);
        chk("R8 attempts", 64'(t_attempt), 64'd2);
        chk("R8 reissued request same", 64'(rec_byte(13)), 64'(exp_req(1'b0, 1'b0, 2'b00)));
        chk("R8 third request same", 64'(rec_byte(26)), 64'(exp_req(1'b0, 1'b0, 2'b00)));
        chk("R10 retry cycles", 64'(g_cyc), 64'((13 * 2 + 47) * 2));
        chk("R8 ok after retry", 64'(result), 64'd0);
        chk("R8 data after retry", 64'(rdata), 64'h0BAD_F00D);
    endtask

    task automatic t_wait_timeout;
        run_txn(1'b0, 1'b1, 2'b10, 32'h0, 8'd0, 4'd1, 99, K_OK, 32'h0, 1'b0, -1);
        chk("R8 timeout result", 64'(result), 64'd1);
        chk("R8 timeout ack", 64'(ack), 64'(K_WAIT));
        chk("R8 timeout bits", 64'(t_gpos), 64'd26);
        chk("R10 timeout cycles", 64'(g_cyc), 64'd52);
        run_txn(1'b0, 1'b1, 2'b10, 32'h0, 8'd0, 4'd0, 99, K_OK, 32'h0, 1'b0, -1);
        chk("R8 zero limit single attempt", 64'(t_gpos), 64'd13);
    endtask

    task automatic t_fault;
        run_txn(1'b1, 1'b0, 2'b01, 32'hDEAD_BEEF, 8'd0, 4'd3, 0, K_FAULT, 32'h0, 1'b0, -1);
        chk("R9 fault result", 64'(result), 64'd2);
        chk("R5 fault ack", 64'(ack), 64'(K_FAULT));
        chk("R9 fault no data bits", 64'(t_gpos), 64'd13);
        chk("R9 line released after ack", 64'(oe_count(8, 12)), 64'd0);
        chk("R10 fault cycles", 64'(g_cyc), 64'd26);
    endtask

    task automatic t_proto;
        run_txn(1'b0, 1'b0, 2'b00, 32'h0, 8'd1, 4'd3, 0, 3'b111, 32'h0, 1'b0, -1);
        chk("R5 protocol result", 64'(result), 64'd3);
        chk("R5 protocol ack", 64'(ack), 64'd7);
        chk("R9 protocol no data", 64'(t_gpos), 64'd13);
        run_txn(1'b0, 1'b0, 2'b00, 32'h0, 8'd0, 4'd3, 0, 3'b011, 32'h0, 1'b0, -1);
        chk("R5 reserved 011 is protocol", 64'(result), 64'd3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read_ok();
        t_read_slow();
        t_write_ok();
        t_parity_bad();
        t_wait_retry();
        t_wait_timeout();
        t_fault();
        t_proto();
        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule